// File: doc/BRIEF.md
# Microstep Phase Position Sequencer

This block tracks the electrical position of one two-phase stepper channel and turns it into current targets for the two coils. A position index covers one electrical cycle in 64 equal positions of 5.625 degrees. Each clock cycle in which the step input is high and the channel is enabled moves the index by one position, up or down depending on the direction input. The index wraps at both ends of the cycle.

From the index the block derives the sign and magnitude of the current wanted in each phase. Phase A follows the absolute sine of the electrical angle and phase B the absolute cosine. A single quarter-wave table of 17 amplitudes is read forwards or backwards depending on the quarter. Each amplitude is then scaled by one of two 4-bit current codes, picked by a select input, and registered. An external current regulator uses the polarity bits, the 7-bit magnitudes and a high-impedance request to drive the bridges.

Top module: `ustep_phase_seq`

## Requirements
- R1: While reset is asserted and on the first clock after it, the index is 0. Outputs after reset: hiz_o=1, mag_a_o=0, mag_b_o=0, pol_a_o=0, pol_b_o=0.
- R2: The index has 64 positions. It wraps from 63 to 0 when moving forward and from 0 to 63 when moving in reverse.
- R3: Each rising clock edge with en_i=1 and step_i=1 moves the index by one. It adds one when dir_i=0 and subtracts one when dir_i=1.
- R4: Write the index as p = 16*q + k, with k from 0 to 15. The amplitude table T[0..16] is 0,12,25,37,49,60,71,81,90,98,106,112,117,122,125,126,127. For even q, phase A uses T[k] and phase B uses T[16-k]. For odd q, phase A uses T[16-k] and phase B uses T[k].
- R5: pol_a_o is 1 (negative current) for indices 32 to 63. pol_b_o is 1 for indices 16 to 47. Otherwise each polarity bit is 0.
- R6: Each magnitude output equals floor(T * (code + 1) / 16), where code is the selected 4-bit current code.
- R7: cur_sel_i=0 selects scale1_i and cur_sel_i=1 selects scale2_i. A change of select or code shows at the outputs after one rising edge.
- R8: While en_i=0, step_i has no effect on the index. After the next edge, hiz_o is 1 and both magnitudes are 0.
- R9: A step sampled at one rising edge shows at the outputs after the following rising edge. The outputs lag the index by exactly one register.
- R10: When en_i returns to 1, the outputs resume from the index held while disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| step_i | input | 1 | Step request, one position per clock while high |
| dir_i | input | 1 | 0 forward (increment), 1 reverse (decrement) |
| en_i | input | 1 | Channel enable; 0 requests high impedance |
| cur_sel_i | input | 1 | Chooses scale1_i (0) or scale2_i (1) |
| scale1_i | input | 4 | First current scale code |
| scale2_i | input | 4 | Second current scale code |
| pol_a_o | output | 1 | Phase A polarity, 1 = negative |
| pol_b_o | output | 1 | Phase B polarity, 1 = negative |
| mag_a_o | output | 7 | Phase A scaled magnitude |
| mag_b_o | output | 7 | Phase B scaled magnitude |
| hiz_o | output | 1 | High-impedance request for the bridges |

## Verification
Runs of steps are applied with varying lengths and directions. They land the index in every quarter, which separates the forward from the backward table read and the polarity of each phase. Two runs cross the wrap point, one in each direction, so a counter that saturates or mis-wraps gives a wrong final position. The scale codes move between 0, 7, 9 and 15 under both select values. The low codes expose the floor division and the top code exposes the offset. Stepping while disabled, then re-enabling, shows whether the index was held. A single isolated step, sampled on each edge, pins down the one-register output lag.

// File: rtl/ustep_pkg.sv
package ustep_pkg;

   // Sine of k * 90/16 degrees in Q15 for k = 0..16 (32768 = full scale)
   function automatic int sin_q15(input int k);
      case (k)
         0:  sin_q15 = 0;
         1:  sin_q15 = 3212;
         2:  sin_q15 = 6393;
         3:  sin_q15 = 9512;
         4:  sin_q15 = 12540;
         5:  sin_q15 = 15447;
         6:  sin_q15 = 18205;
         7:  sin_q15 = 20788;
         8:  sin_q15 = 23170;
         9:  sin_q15 = 25330;
         10: sin_q15 = 27246;
         11: sin_q15 = 28899;
         12: sin_q15 = 30274;
         13: sin_q15 = 31357;
         14: sin_q15 = 32138;
         15: sin_q15 = 32610;
         default: sin_q15 = 32768;
      endcase
   endfunction

   // Rounded table amplitude for an output of amp_w bits
   function automatic int quarter_amp(input int k, input int amp_w);
      longint full;
      full = (longint'(1) << amp_w) - 1;
      quarter_amp = int'((longint'(sin_q15(k)) * full + 16384) >>> 15);
   endfunction

   typedef enum logic {PH_A = 1'b0, PH_B = 1'b1} phase_e;

endpackage

// File: rtl/ustep_pos_ctr.sv
module ustep_pos_ctr #(
   parameter int POS_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic             dir_i,
   output logic [POS_W-1:0] pos_o
);

   localparam logic [POS_W-1:0] ONE = POS_W'(1);

   logic [POS_W-1:0] pos_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         pos_q <= '0;
      else if (adv_i)
         pos_q <= dir_i ? (pos_q - ONE) : (pos_q + ONE);
   end

   assign pos_o = pos_q;

   // R3
   fwd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && !dir_i) |=> (pos_q == $past(pos_q) + ONE))
      else $error("forward step did not advance index");

   // R3
   rev_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_i && dir_i) |=> (pos_q == $past(pos_q) - ONE))
      else $error("reverse step did not retreat index");

   // R8
   pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_i |=> $stable(pos_q))
      else $error("index moved without a step");

endmodule

// File: rtl/ustep_quad_lut.sv
module ustep_quad_lut #(
   parameter int POS_W = 6,
   parameter int AMP_W = 7
) (
   input  logic [POS_W-1:0] pos_i,
   output logic [AMP_W-1:0] amp_a_o,
   output logic [AMP_W-1:0] amp_b_o,
   output logic             neg_a_o,
   output logic             neg_b_o
);

   localparam int QTR_W  = POS_W - 2;
   localparam int QSTEPS = 1 << QTR_W;

   logic [AMP_W-1:0] tbl [QSTEPS+1];

   for (genvar g = 0; g <= QSTEPS; g++) begin : g_tbl
      assign tbl[g] = AMP_W'(ustep_pkg::quarter_amp(g, AMP_W));
   end

   logic [QTR_W:0] k_up;
   logic [QTR_W:0] k_dn;
   logic           odd_qtr;

   always_comb begin
      k_up    = {1'b0, pos_i[QTR_W-1:0]};
      k_dn    = (QTR_W+1)'(QSTEPS) - k_up;
      odd_qtr = pos_i[QTR_W];
      amp_a_o = odd_qtr ? tbl[k_dn] : tbl[k_up];
      amp_b_o = odd_qtr ? tbl[k_up] : tbl[k_dn];
      neg_a_o = pos_i[POS_W-1];
      neg_b_o = pos_i[POS_W-1] ^ pos_i[POS_W-2];
   end

endmodule

// File: rtl/ustep_scaler.sv
module ustep_scaler #(
   parameter int AMP_W   = 7,
   parameter int SCL_W   = 4,
   parameter int SCL_OFS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AMP_W-1:0] amp_i,
   input  logic [SCL_W-1:0] code_i,
   input  logic             zero_i,
   output logic [AMP_W-1:0] mag_o
);

   localparam int MUL_W  = SCL_W + 2;
   localparam int PROD_W = AMP_W + MUL_W;

   logic [MUL_W-1:0]  mult;
   logic [PROD_W-1:0] prod;
   logic [AMP_W-1:0]  mag_q;

   always_comb begin
      mult = MUL_W'(code_i) + MUL_W'(SCL_OFS);
      prod = PROD_W'(amp_i) * PROD_W'(mult);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         mag_q <= '0;
      else if (zero_i)
         mag_q <= '0;
      else
         mag_q <= AMP_W'(prod >> SCL_W);
   end

   assign mag_o = mag_q;

   if (SCL_OFS <= (1 << SCL_W)) begin : g_bounded
      // R6
      scaled_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (mag_q <= $past(amp_i)))
         else $error("scaled magnitude above table amplitude");
   end

endmodule

// File: rtl/ustep_phase_seq.sv
module ustep_phase_seq #(
   parameter int POS_W   = 6,
   parameter int MAG_W   = 7,
   parameter int SCL_W   = 4,
   parameter int SCL_OFS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             dir_i,
   input  logic             en_i,
   input  logic             cur_sel_i,
   input  logic [SCL_W-1:0] scale1_i,
   input  logic [SCL_W-1:0] scale2_i,
   output logic             pol_a_o,
   output logic             pol_b_o,
   output logic [MAG_W-1:0] mag_a_o,
   output logic [MAG_W-1:0] mag_b_o,
   output logic             hiz_o
);

   localparam int QTR_W   = POS_W - 2;
   localparam int N_PHASE = 2;

   initial begin
      pos_w_chk: assert (POS_W == 6)
         else $error("quarter table holds 16 steps; POS_W must be 6");
      mag_w_chk: assert (MAG_W >= 2 && MAG_W <= 16)
         else $error("MAG_W out of range");
      scl_w_chk: assert (SCL_W >= 1 && SCL_W <= 8)
         else $error("SCL_W out of range");
   end

   logic [POS_W-1:0] pos;
   logic [MAG_W-1:0] amp [N_PHASE];
   logic [MAG_W-1:0] mag [N_PHASE];
   logic             neg_a, neg_b;
   logic [SCL_W-1:0] code_sel;
   logic             pol_a_q, pol_b_q, hiz_q;

   ustep_pos_ctr #(.POS_W(POS_W)) pos_i (
      .clk   (clk),
      .rst_n (rst_n),
      .adv_i (en_i & step_i),
      .dir_i (dir_i),
      .pos_o (pos)
   );

   ustep_quad_lut #(.POS_W(POS_W), .AMP_W(MAG_W)) lut_i (
      .pos_i   (pos),
      .amp_a_o (amp[ustep_pkg::PH_A]),
      .amp_b_o (amp[ustep_pkg::PH_B]),
      .neg_a_o (neg_a),
      .neg_b_o (neg_b)
   );

   assign code_sel = cur_sel_i ? scale2_i : scale1_i;

   for (genvar ph = 0; ph < N_PHASE; ph++) begin : g_phase
      ustep_scaler #(.AMP_W(MAG_W), .SCL_W(SCL_W), .SCL_OFS(SCL_OFS)) scl_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .amp_i  (amp[ph]),
         .code_i (code_sel),
         .zero_i (~en_i),
         .mag_o  (mag[ph])
      );
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pol_a_q <= 1'b0;
         pol_b_q <= 1'b0;
         hiz_q   <= 1'b1;
      end else begin
         pol_a_q <= neg_a;
         pol_b_q <= neg_b;
         hiz_q   <= ~en_i;
      end
   end

   assign pol_a_o = pol_a_q;
   assign pol_b_o = pol_b_q;
   assign hiz_o   = hiz_q;
   assign mag_a_o = mag[ustep_pkg::PH_A];
   assign mag_b_o = mag[ustep_pkg::PH_B];

   // R8
   hiz_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> (hiz_o && mag_a_o == '0 && mag_b_o == '0))
      else $error("disabled channel drives current");

   // R4
   quad_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pos[QTR_W-1:0] == '0) |->
         ((pos[QTR_W] ? amp[ustep_pkg::PH_B] : amp[ustep_pkg::PH_A]) == '0))
      else $error("quarter start amplitude not zero");

endmodule

// File: tb/ustep_phase_seq_tb.sv
`timescale 1ns/1ps
module ustep_phase_seq_tb_top;

   typedef struct packed {
      logic [7:0] n;
      logic       dir;
      logic       sel;
      logic [3:0] c1;
      logic [3:0] c2;
      logic [5:0] pos;
   } vec_t;

   // Index is 1 before the first vector (after the latency test)
   localparam vec_t VECS [7] = '{
      '{8'd15, 1'b0, 1'b0, 4'd15, 4'd3,  6'd16},
      '{8'd10, 1'b0, 1'b1, 4'd15, 4'd7,  6'd26},
      '{8'd20, 1'b0, 1'b0, 4'd0,  4'd7,  6'd46},
      '{8'd20, 1'b0, 1'b0, 4'd9,  4'd7,  6'd2},
      '{8'd5,  1'b1, 1'b1, 4'd9,  4'd15, 6'd61},
      '{8'd29, 1'b1, 1'b0, 4'd15, 4'd15, 6'd32},
      '{8'd3,  1'b1, 1'b1, 4'd15, 4'd0,  6'd29}
   };

   logic       clk = 1'b0;
   logic       rst_n, step, dir, en, sel;
   logic [3:0] c1, c2;
   logic       pol_a, pol_b, hiz;
   logic [6:0] mag_a, mag_b;

   int checks = 0;
   int errors = 0;

   always #2.5 clk = ~clk;

   ustep_phase_seq dut_i (
      .clk(clk), .rst_n(rst_n), .step_i(step), .dir_i(dir), .en_i(en),
      .cur_sel_i(sel), .scale1_i(c1), .scale2_i(c2),
      .pol_a_o(pol_a), .pol_b_o(pol_b), .mag_a_o(mag_a), .mag_b_o(mag_b),
      .hiz_o(hiz)
   );

   function automatic int tbl(input int k);
      case (k)
         0: tbl = 0;    1: tbl = 12;   2: tbl = 25;   3: tbl = 37;
         4: tbl = 49;   5: tbl = 60;   6: tbl = 71;   7: tbl = 81;
         8: tbl = 90;   9: tbl = 98;   10: tbl = 106; 11: tbl = 112;
         12: tbl = 117; 13: tbl = 122; 14: tbl = 125; 15: tbl = 126;
         default: tbl = 127;
      endcase
   endfunction

   function automatic int exp_mag(input int p, input bit ph_b, input int code);
      int q, k, a;
      q = (p / 16) % 2;
      k = p % 16;
      if ((q == 1) ^ ph_b) a = tbl(16 - k);
      else                 a = tbl(k);
      exp_mag = (a * (code + 1)) / 16;
   endfunction

   task automatic chk(input string req, input int act, input int expv);
      checks++;
      if (act != expv) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
      end
   endtask

   task automatic chk_pos(input string req, input int p, input int code);
      chk({req, " R4/R6 mag_a"}, mag_a, exp_mag(p, 1'b0, code));
      chk({req, " R4/R6 mag_b"}, mag_b, exp_mag(p, 1'b1, code));
      chk({req, " R5 pol_a"}, pol_a, (p >= 32) ? 1 : 0);
      chk({req, " R5 pol_b"}, pol_b, (p >= 16 && p < 48) ? 1 : 0);
      chk({req, " R8 hiz"}, hiz, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      rst_n = 1'b0; step = 1'b0; dir = 1'b0; en = 1'b0; sel = 1'b0;
      c1 = 4'd15; c2 = 4'd0;
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 hiz", hiz, 1);
      chk("R1 mag_a", mag_a, 0);
      chk("R1 mag_b", mag_b, 0);
      chk("R1 pol_a", pol_a, 0);
      chk("R1 pol_b", pol_b, 0);
      rst_n = 1'b1; en = 1'b1;
      @(negedge clk);
      chk_pos("R1 index0", 0, 15);

      // R9 latency: one step, outputs lag the index by one edge
      step = 1'b1;
      @(negedge clk);
      step = 1'b0;
      chk("R9 old mag_a", mag_a, 0);
      @(negedge clk);
      chk("R9 new mag_a", mag_a, 12);

      // R2 R3 R4 R5 R6 R7 vector walk
      for (int i = 0; i < 7; i++) begin
         dir = VECS[i].dir; sel = VECS[i].sel;
         c1 = VECS[i].c1; c2 = VECS[i].c2;
         step = 1'b1;
         repeat (int'(VECS[i].n)) @(negedge clk);
         step = 1'b0;
         @(negedge clk);
         chk_pos($sformatf("R2/R3 vec%0d", i), int'(VECS[i].pos),
                 VECS[i].sel ? int'(VECS[i].c2) : int'(VECS[i].c1));
      end

      // R7 select switch without stepping (index 29, c1=15, c2=0)
      sel = 1'b0;
      @(negedge clk);
      chk("R7 sel0 mag_a", mag_a, exp_mag(29, 1'b0, 15));
      sel = 1'b1;
      @(negedge clk);
      chk("R7 sel1 mag_a", mag_a, exp_mag(29, 1'b0, 0));
      chk("R7 sel1 mag_b", mag_b, exp_mag(29, 1'b1, 0));

      // R8 steps ignored while disabled
      en = 1'b0; dir = 1'b0; step = 1'b1;
      repeat (7) @(negedge clk);
      chk("R8 hiz", hiz, 1);
      chk("R8 mag_a", mag_a, 0);
      chk("R8 mag_b", mag_b, 0);
      step = 1'b0; en = 1'b1;
      @(negedge clk);
      // R10 resume from held index 29
      chk_pos("R10 resume", 29, 0);

      // R1 reset mid-run returns index to 0
      rst_n = 1'b0;
      @(negedge clk);
      chk("R1 rerun hiz", hiz, 1);
      rst_n = 1'b1; sel = 1'b0; c1 = 4'd15;
      @(negedge clk);
      chk_pos("R1 rerun index0", 0, 15);

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule